// File: doc/BRIEF.md
# Banked Data Memory Addressing Unit

This block sits between an 8-bit processor core and a 4096-byte data RAM. It turns the 8-bit operand address carried in an instruction into a 12-bit memory address. The upper four address bits come from a bank register, or from a fixed window when the instruction asks for window addressing. In window mode the low 128 operand addresses reach the bottom of bank 0, where general-purpose variables live. The high 128 operand addresses reach the top of bank 15, where special-function registers live. Window mode never needs the bank register, and it never needs a cycle to update that register first.

A second path copies one byte between two full 12-bit addresses, with no bank register involved. The copy takes two cycles. It reads the source in the cycle it is accepted and writes the destination in the next cycle, and `mv_busy` is high during that second cycle.

Core requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low while a copy is writing, and it is also low whenever `mv_valid` is high, because the copy has priority. A producer that sees `req_ready` low keeps its request stable until it is taken. Read responses cannot be held off: `rsp_valid` is a single-cycle pulse that the core must capture. The copy port follows the same handshake rule, with `mv_ready` low only while a copy is writing.

Top module: `bank_addr_unit`

## Requirements
- R1: With `req_access`=1 (banked), `req_eaddr` equals {`bank_sel`, `req_opaddr`}.
- R2: With `req_access`=0 and `req_opaddr` in 00h..7Fh, `req_eaddr` = 000h + `req_opaddr`, whatever the bank register holds.
- R3: With `req_access`=0 and `req_opaddr` in 80h..FFh, `req_eaddr` = F00h + `req_opaddr` (F80h..FFFh), whatever the bank register holds.
- R4: `bank_sel` is 0 after reset. A bank write loads `bank_wdata` on the clock edge. An access presented in the same cycle still uses the old bank value.
- R5: An accepted read raises `rsp_valid` exactly one cycle later, with the byte stored at `req_eaddr`. An accepted write stores `req_wdata` at `req_eaddr` on that clock edge.
- R6: An accepted copy reads `mv_src` and writes that byte to `mv_dst` one cycle later. Both are full 12-bit addresses, and the bank register has no effect on either. `mv_busy` is high for exactly the one cycle that follows acceptance.
- R7: `mv_ready` equals not `mv_busy`. `req_ready` is low while `mv_busy` or `mv_valid` is high, and high otherwise.
- R8: RAM contents are not cleared by reset. A byte written before a reset reads back unchanged after it.
- R9: `rsp_valid` stays low in every cycle that does not follow an accepted read, including after writes, refused requests and copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 4 | New bank register value |
| bank_sel | output | 4 | Current bank register value |
| req_valid | input | 1 | Core access request valid |
| req_ready | output | 1 | Core access request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_access | input | 1 | 1 = banked addressing, 0 = window addressing |
| req_opaddr | input | 8 | Operand address from the opcode |
| req_wdata | input | 8 | Write data |
| req_eaddr | output | 12 | Effective address formed for the request |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 8 | Read data |
| mv_valid | input | 1 | Copy request valid |
| mv_ready | output | 1 | Copy request can be taken |
| mv_src | input | 12 | Copy source address |
| mv_dst | input | 12 | Copy destination address |
| mv_busy | output | 1 | Copy is in its write cycle |

## Verification
The hardest situations to reach are the ones where two things happen in the same cycle. One is a bank write presented together with a banked access, which must use the old bank value. Another is a copy request colliding with a core request, which must be refused. The third is a reset landing between writes and reads, after which the RAM contents must remain. The stimulus sweeps all 16 bank values in both addressing modes across 00h, 7Fh, 80h and FFh. It then drives directed collisions and a reset between a write and its read-back, and finishes with a long run of random mixed traffic. A behavioural model compares every port on every clock.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int BAU_BANK_W = 4;
  localparam int BAU_OFS_W  = 8;
  localparam int BAU_DATA_W = 8;

  typedef enum logic {
    ACC_WINDOW = 1'b0,
    ACC_BANKED = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/bau_addr_map.sv
module bau_addr_map
  import bau_pkg::*;
#(
  parameter int BANK_W = BAU_BANK_W,
  parameter int OFS_W  = BAU_OFS_W,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  acc_mode_e           mode,
  input  logic [BANK_W-1:0]   bank,
  input  logic [OFS_W-1:0]    ofs,
  output logic [ADDR_W-1:0]   eaddr
);
  localparam logic [BANK_W-1:0] LOW_BANK  = '0;
  localparam logic [BANK_W-1:0] HIGH_BANK = '1;

  logic upper_half;
  assign upper_half = ofs[OFS_W-1];

  always_comb begin
    unique case (mode)
      ACC_BANKED: eaddr = {bank, ofs};
      default:    eaddr = {(upper_half ? HIGH_BANK : LOW_BANK), ofs};
    endcase
  end
endmodule

// File: rtl/bau_ram.sv
module bau_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // No reset: contents survive every reset.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end
endmodule

// File: rtl/bau_move_ctrl.sv
module bau_move_ctrl #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_valid,
  input  logic [ADDR_W-1:0] mv_dst,
  output logic              mv_ready,
  output logic              mv_fire,
  output logic              busy,
  output logic [ADDR_W-1:0] dst_q
);
  assign mv_ready = !busy;
  assign mv_fire  = mv_valid && mv_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      dst_q <= '0;
    end else begin
      busy <= mv_fire;
      if (mv_fire) dst_q <= mv_dst;
    end
  end

  assert_move_enters_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_fire |=> busy);
  assert_busy_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bau_pkg::*;
#(
  parameter int BANK_W = BAU_BANK_W,
  parameter int OFS_W  = BAU_OFS_W,
  parameter int DATA_W = BAU_DATA_W,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [BANK_W-1:0] bank_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_access,
  input  logic [OFS_W-1:0]  req_opaddr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] req_eaddr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              mv_valid,
  output logic              mv_ready,
  input  logic [ADDR_W-1:0] mv_src,
  input  logic [ADDR_W-1:0] mv_dst,
  output logic              mv_busy
);
  logic [BANK_W-1:0] bank_q;
  logic              mv_fire;
  logic [ADDR_W-1:0] mv_dst_q;
  logic              req_fire;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata;
  end
  assign bank_sel = bank_q;

  bau_addr_map #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_map (
    .mode  (acc_mode_e'(req_access)),
    .bank  (bank_q),
    .ofs   (req_opaddr),
    .eaddr (req_eaddr)
  );

  bau_move_ctrl #(.ADDR_W(ADDR_W)) u_move (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_valid (mv_valid),
    .mv_dst   (mv_dst),
    .mv_ready (mv_ready),
    .mv_fire  (mv_fire),
    .busy     (mv_busy),
    .dst_q    (mv_dst_q)
  );

  assign req_ready = !mv_busy && !mv_valid;
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    if (mv_busy) begin
      ram_addr  = mv_dst_q;
      ram_we    = 1'b1;
      ram_wdata = ram_rdata;
    end else if (mv_fire) begin
      ram_addr  = mv_src;
      ram_we    = 1'b0;
      ram_wdata = req_wdata;
    end else begin
      ram_addr  = req_eaddr;
      ram_we    = req_fire && req_write;
      ram_wdata = req_wdata;
    end
  end

  bau_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_fire && !req_write;
  end
  assign rsp_data = ram_rdata;

  assert_window_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_access && !req_opaddr[OFS_W-1]) |-> (req_eaddr[ADDR_W-1:OFS_W] == '0));
  assert_window_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_access && req_opaddr[OFS_W-1]) |-> (req_eaddr[ADDR_W-1:OFS_W] == '1));
  assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_sel == $past(bank_wdata)));
  assert_read_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  assert_no_stray_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);
  assert_blocked_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mv_busy |-> (!req_ready && !mv_ready));
endmodule

// File: tb/bank_addr_unit_test.sv
`timescale 1ns/1ps
module bank_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic [3:0]  bank_sel;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_access = 1'b0;
  logic [7:0]  req_opaddr = '0;
  logic [7:0]  req_wdata = '0;
  logic [11:0] req_eaddr;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        mv_valid = 1'b0;
  logic        mv_ready;
  logic [11:0] mv_src = '0;
  logic [11:0] mv_dst = '0;
  logic        mv_busy;

  always #2.5 clk = ~clk;

  bank_addr_unit uut (.*);

  int tests = 0;
  int fails = 0;
  string data_tag = "R5";

  // Reference model state
  logic [7:0]  m_mem [4096];
  bit          m_known [4096];
  int          m_bank = 0;
  bit          m_busy = 0;
  int          m_dst = 0;
  logic [7:0]  m_mdata = '0;
  bit          m_mknown = 0;
  bit          e_rv = 0;
  logic [7:0]  e_data = '0;
  bit          e_known = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_eaddr();
    if (req_access) return (m_bank << 8) | int'(req_opaddr);
    if (req_opaddr[7]) return 12'hF00 | int'(req_opaddr);
    return int'(req_opaddr);
  endfunction

  task automatic check_comb();
    int ea;
    string t;
    ea = model_eaddr();
    t = req_access ? "R1" : (req_opaddr[7] ? "R3" : "R2");
    chk(req_eaddr == 12'(ea), t, "eaddr", int'(req_eaddr), ea);
    chk(req_ready == (!m_busy && !mv_valid), "R7", "req_ready", int'(req_ready),
        int'(!m_busy && !mv_valid));
    chk(mv_ready == !m_busy, "R7", "mv_ready", int'(mv_ready), int'(!m_busy));
  endtask

  task automatic model_update();
    bit acc_mv, acc_req;
    int ea;
    acc_mv  = mv_valid && !m_busy;
    acc_req = req_valid && !m_busy && !mv_valid;
    ea = model_eaddr();
    e_rv = 0;
    if (m_busy) begin
      m_mem[m_dst] = m_mdata;
      m_known[m_dst] = m_mknown;
      m_busy = 0;
    end else if (acc_mv) begin
      m_mdata = m_mem[mv_src];
      m_mknown = m_known[mv_src];
      m_dst = int'(mv_dst);
      m_busy = 1;
    end else if (acc_req) begin
      if (req_write) begin
        m_mem[ea] = req_wdata;
        m_known[ea] = 1;
      end else begin
        e_rv = 1;
        e_data = m_mem[ea];
        e_known = m_known[ea];
      end
    end
    if (bank_we) m_bank = int'(bank_wdata);
  endtask

  task automatic check_regs();
    chk(bank_sel == 4'(m_bank), "R4", "bank_sel", int'(bank_sel), m_bank);
    chk(mv_busy == m_busy, "R6", "mv_busy", int'(mv_busy), int'(m_busy));
    chk(rsp_valid == e_rv, e_rv ? "R5" : "R9", "rsp_valid", int'(rsp_valid), int'(e_rv));
    if (e_rv && e_known)
      chk(rsp_data == e_data, data_tag, "rsp_data", int'(rsp_data), int'(e_data));
  endtask

  task automatic step();
    #1;
    check_comb();
    @(posedge clk);
    model_update();
    #1;
    check_regs();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    bank_we = 0; req_valid = 0; req_write = 0; mv_valid = 0;
  endtask

  task automatic idle();
    clear_inputs();
    step();
  endtask

  task automatic set_bank(input int b);
    clear_inputs();
    bank_we = 1; bank_wdata = 4'(b);
    step();
    clear_inputs();
  endtask

  task automatic do_write(input bit acc, input int op, input int d);
    clear_inputs();
    req_valid = 1; req_write = 1; req_access = acc;
    req_opaddr = 8'(op); req_wdata = 8'(d);
    step();
    clear_inputs();
  endtask

  task automatic do_read(input bit acc, input int op);
    clear_inputs();
    req_valid = 1; req_write = 0; req_access = acc; req_opaddr = 8'(op);
    step();
    clear_inputs();
  endtask

  task automatic do_move(input int s, input int d);
    clear_inputs();
    mv_valid = 1; mv_src = 12'(s); mv_dst = 12'(d);
    step();
    clear_inputs();
  endtask

  task automatic apply_reset();
    clear_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    m_bank = 0; m_busy = 0; e_rv = 0;
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) m_known[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state (R4, R6, R9)
    check_regs();
    idle();

    // R1/R2/R3: sweep every bank in both modes, incl. 7Fh/80h edge
    for (int b = 0; b < 16; b++) begin
      set_bank(b);
      for (int k = 0; k < 5; k++) begin
        int op;
        op = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : (k == 2) ? 8'h80 :
             (k == 3) ? 8'hFF : (b * 16 + 3);
        for (int a = 0; a < 2; a++) begin
          do_write(a[0], op, (b * 37 + k * 11 + a * 5) & 8'hFF);
          do_read(a[0], op);
        end
      end
    end

    // R4: bank write in the same cycle as a banked access uses old bank
    set_bank(3);
    do_write(1, 8'h10, 8'hA5);
    clear_inputs();
    bank_we = 1; bank_wdata = 4'h9;
    req_valid = 1; req_access = 1; req_opaddr = 8'h10;
    step();
    clear_inputs();
    do_read(1, 8'h10);  // now hits 910h

    // R6: copy with full addresses, bank register ignored
    data_tag = "R6";
    set_bank(5);
    do_write(1, 8'h23, 8'h5C);     // 523h
    do_move(12'h523, 12'hABC);
    idle();
    set_bank(4'hA);
    do_read(1, 8'hBC);
    do_move(12'hABC, 12'h07E);
    idle();
    do_read(0, 8'h7E);             // window low -> 07Eh

    // R7: copy and request together, request refused
    clear_inputs();
    mv_valid = 1; mv_src = 12'h07E; mv_dst = 12'hF90;
    req_valid = 1; req_write = 1; req_access = 1; req_opaddr = 8'h00; req_wdata = 8'h11;
    step();
    clear_inputs();
    req_valid = 1; req_write = 0; req_access = 0; req_opaddr = 8'h90;
    step();                        // refused while busy (R7, R9)
    step();                        // accepted now -> F90h
    clear_inputs();
    idle();

    // R8: data kept across reset
    data_tag = "R8";
    do_write(0, 8'h42, 8'hC3);
    do_write(0, 8'hE1, 8'h3C);
    apply_reset();
    check_regs();
    do_read(0, 8'h42);
    do_read(0, 8'hE1);
    idle();

    // Random mixed traffic
    data_tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      clear_inputs();
      bank_we    = ($urandom_range(9) == 0);
      bank_wdata = 4'($urandom);
      req_valid  = ($urandom_range(9) < 7);
      req_write  = $urandom_range(1) == 1;
      req_access = $urandom_range(1) == 1;
      req_opaddr = 8'($urandom);
      req_wdata  = 8'($urandom);
      mv_valid   = ($urandom_range(9) == 0);
      mv_src     = 12'($urandom);
      mv_dst     = 12'($urandom);
      step();
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule